// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one-word host requests into complete bus cycle sequences for a NAND flash device on an 8-bit multiplexed I/O bus. The host gives an operation code, a 24-bit address and a byte count. The sequencer then produces each needed bus cycle. A command byte goes out with the command latch strobe high. Address bytes go out with the address latch strobe high. Data bytes go out with both latch strobes low. Every byte is framed by a write-enable or read-enable pulse of a width set by a parameter.

The supported requests are page read, spare-area read, ID read, status read, page program, block erase and device reset. An optional extended mode adds erase suspend. Program and erase are two-phase sequences that end with a confirm opcode. After the confirm, the block waits for the device to become ready, reads the status byte and reports pass or fail. Except for status, reset and suspend, a request holds its first command until the ready/busy line shows ready. Bytes read from the array come back one per pulse on a byte-stream port. Bytes to program are taken from the host one per write pulse.

Top module: `nand_seq`

## Requirements
- R1: After reset, busy, done, wr_take, rd_valid, nand_cle, nand_ale, nand_io_oe and nand_wp_n are low, and nand_ce_n, nand_we_n and nand_re_n are high.
- R2: A command byte is presented with nand_cle=1 and nand_ale=0. The opcodes are: op 0 page read 00h, op 1 spare read 50h, op 2 ID read 90h, op 3 status 70h, op 4 program 80h, op 5 erase 60h, op 6 reset FFh, op 7 suspend B0h. nand_cle and nand_ale are never high together.
- R3: Address bytes are presented with nand_ale=1 and nand_cle=0. Page read, spare read and program send req_addr[7:0], then [15:8], then [23:16]. Erase sends [15:8] and then [23:16]. ID read sends a single 00h.
- R4: nand_ale rises once per sequence and stays high from the first address byte to the last, including the gaps between strobes.
- R5: Program sends 80h, three address bytes, then req_len data bytes with both latches low, then confirm 10h. wr_data is taken on each write pulse, and wr_take pulses once per byte.
- R6: Erase sends 60h, two block address bytes, then confirm D0h.
- R7: After a program or erase confirm, the block waits for nand_rb=1 and issues 70h. It then reads one byte and raises done with fail equal to bit 0 of that byte.
- R8: Requests other than status (op 3), reset (op 6) and suspend (op 7) issue no command while nand_rb=0. Status, reset and suspend issue their opcode at once.
- R9: For page and spare reads, after the last address byte the block waits WB_CYC clocks and then for nand_rb=1. It then reads req_len bytes, and each one is returned on rd_data with a one-cycle rd_valid, in order. ID read returns req_len bytes with no wait. Status returns one byte.
- R10: busy is high from the cycle after a request is accepted until the cycle after the one-cycle done pulse. A req_valid seen while busy is high is ignored.
- R11: nand_we_n and nand_re_n pulse low for exactly STROBE_LO clocks and are never low together. nand_io_oe is low whenever nand_re_n is low.
- R12: nand_ce_n is low exactly while busy is high. nand_wp_n is high only while a program or erase request is busy.
- R13: With EXT_MODE=1, op 7 sends B0h without waiting for ready, then waits for ready and completes. With EXT_MODE=0, op 7 is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | 24 | Column, low and high page/block bytes |
| req_len | input | LEN_W | Number of data bytes to read or program |
| wr_data | input | 8 | Program data byte, held until wr_take |
| wr_take | output | 1 | Program byte consumed |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Status bit 0 from the last program or erase |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_io_out | output | 8 | Bus byte driven to the device |
| nand_io_oe | output | 1 | Output enable for nand_io_out |
| nand_io_in | input | 8 | Bus byte from the device |
| nand_rb | input | 1 | Ready (1) / busy (0) from the device |

## Verification
The hardest situation to reach from the ports is a request that arrives while the device is still busy. Whether it goes out depends on the opcode's exemption, and it has to be shown that nothing at all goes onto the bus. The bench device model can hold ready/busy low on demand, independent of its automatic busy windows after confirms and page-read addresses. With that hold in place, the bench issues an ID read, watches the bus stay silent for tens of cycles, and then releases it. It repeats the held state for status, reset and suspend to show that these go out at once. A monitor also flags any non-exempt command strobe and any array read strobe seen while ready/busy is low.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;

   localparam int ADDR_W = 24;

   typedef enum logic [2:0] {
      OP_RD_PAGE  = 3'd0,
      OP_RD_SPARE = 3'd1,
      OP_RD_ID    = 3'd2,
      OP_STATUS   = 3'd3,
      OP_PROGRAM  = 3'd4,
      OP_ERASE    = 3'd5,
      OP_RESET    = 3'd6,
      OP_EXTRA    = 3'd7
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_WAIT, ST_CMD, ST_ADDR, ST_SETTLE, ST_RDATA,
      ST_WDATA, ST_CONF, ST_STCMD, ST_STRD, ST_DONE
   } state_e;

   localparam logic [7:0] CODE_STATUS = 8'h70;
   localparam logic [7:0] CODE_PCONF  = 8'h10;
   localparam logic [7:0] CODE_ECONF  = 8'hD0;

   function automatic logic [7:0] first_code(op_e op);
      case (op)
         OP_RD_PAGE:  return 8'h00;
         OP_RD_SPARE: return 8'h50;
         OP_RD_ID:    return 8'h90;
         OP_STATUS:   return CODE_STATUS;
         OP_PROGRAM:  return 8'h80;
         OP_ERASE:    return 8'h60;
         OP_RESET:    return 8'hFF;
         default:     return 8'hB0;
      endcase
   endfunction

   function automatic logic busy_exempt(op_e op);
      return (op == OP_STATUS) || (op == OP_RESET) || (op == OP_EXTRA);
   endfunction

endpackage

// File: rtl/nand_seq_strobe.sv
`timescale 1ns/1ps
module nand_seq_strobe #(
   parameter int STROBE_LO = 2,
   parameter int STROBE_HI = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       is_read,
   input  logic [7:0] io_in,
   output logic       active,
   output logic       fin,
   output logic       we_n,
   output logic       re_n,
   output logic [7:0] cap_byte
);
   localparam int MAXC = (STROBE_LO > STROBE_HI) ? STROBE_LO : STROBE_HI;
   localparam int CW   = $clog2(MAXC + 1);

   typedef enum logic [1:0] {P_OFF, P_LOW, P_HIGH} phase_e;

   phase_e          ph;
   logic [CW-1:0]   cnt;
   logic            rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= P_OFF;
         cnt      <= '0;
         rd_q     <= 1'b0;
         cap_byte <= '0;
      end else begin
         case (ph)
            P_OFF: if (start) begin
               ph   <= P_LOW;
               cnt  <= '0;
               rd_q <= is_read;
            end
            P_LOW: if (cnt == CW'(STROBE_LO - 1)) begin
               ph  <= P_HIGH;
               cnt <= '0;
               if (rd_q) cap_byte <= io_in;
            end else begin
               cnt <= cnt + CW'(1);
            end
            default: if (cnt == CW'(STROBE_HI - 1)) begin
               ph  <= P_OFF;
               cnt <= '0;
            end else begin
               cnt <= cnt + CW'(1);
            end
         endcase
      end
   end

   assign active = (ph != P_OFF);
   assign fin    = (ph == P_HIGH) && (cnt == CW'(STROBE_HI - 1));
   assign we_n   = !((ph == P_LOW) && !rd_q);
   assign re_n   = !((ph == P_LOW) && rd_q);

endmodule

// File: rtl/nand_seq_ctrl.sv
`timescale 1ns/1ps
module nand_seq_ctrl
   import nand_seq_pkg::*;
#(
   parameter int LEN_W    = 10,
   parameter int WB_CYC   = 4,
   parameter bit EXT_MODE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [7:0]        wr_data,
   input  logic              nand_rb,
   input  logic              cyc_active,
   input  logic              cyc_fin,
   input  logic [7:0]        cap_byte,
   output logic              cyc_start,
   output logic              cyc_rd,
   output logic [7:0]        bus_byte,
   output logic              cle,
   output logic              ale,
   output logic              oe,
   output logic              wr_take,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              guard_off
);
   localparam int WB_W = $clog2(WB_CYC + 1);

   state_e              st;
   op_e                 op_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [LEN_W-1:0]    len_q;
   logic [LEN_W-1:0]    idx;
   logic [WB_W-1:0]     wait_cnt;
   logic                ext_ok;
   logic                accept;
   logic [LEN_W-1:0]    addr_last;
   logic                bus_state;

   generate
      if (EXT_MODE) begin : g_ext
         assign ext_ok = 1'b1;
      end else begin : g_base
         assign ext_ok = 1'b0;
      end
   endgenerate

   assign accept = (st == ST_IDLE) && req_valid &&
                   ((op_e'(req_op) != OP_EXTRA) || ext_ok);

   always_comb begin
      case (op_q)
         OP_RD_ID: addr_last = LEN_W'(0);
         OP_ERASE: addr_last = LEN_W'(1);
         default:  addr_last = LEN_W'(2);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         op_q     <= OP_RD_PAGE;
         addr_q   <= '0;
         len_q    <= '0;
         idx      <= '0;
         wait_cnt <= '0;
         fail     <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= (st == ST_RDATA) && cyc_fin;
         if ((st == ST_RDATA) && cyc_fin) rd_data <= cap_byte;
         case (st)
            ST_IDLE: if (accept) begin
               op_q   <= op_e'(req_op);
               addr_q <= req_addr;
               len_q  <= req_len;
               idx    <= '0;
               fail   <= 1'b0;
               st     <= busy_exempt(op_e'(req_op)) ? ST_CMD : ST_WAIT;
            end
            ST_WAIT: if (nand_rb) st <= ST_CMD;
            ST_CMD: if (cyc_fin) begin
               idx <= '0;
               case (op_q)
                  OP_STATUS:          st <= ST_RDATA;
                  OP_RESET, OP_EXTRA: st <= ST_SETTLE;
                  default:            st <= ST_ADDR;
               endcase
            end
            ST_ADDR: if (cyc_fin) begin
               if (idx == addr_last) begin
                  idx <= '0;
                  case (op_q)
                     OP_RD_ID:   st <= ST_RDATA;
                     OP_PROGRAM: st <= ST_WDATA;
                     OP_ERASE:   st <= ST_CONF;
                     default:    st <= ST_SETTLE;
                  endcase
               end else begin
                  idx <= idx + LEN_W'(1);
               end
            end
            ST_SETTLE: begin
               if (wait_cnt != WB_W'(WB_CYC - 1)) begin
                  wait_cnt <= wait_cnt + WB_W'(1);
               end else if (nand_rb) begin
                  wait_cnt <= '0;
                  case (op_q)
                     OP_PROGRAM, OP_ERASE: st <= ST_STCMD;
                     OP_RESET, OP_EXTRA:   st <= ST_DONE;
                     default:              st <= ST_RDATA;
                  endcase
               end
            end
            ST_RDATA: if (cyc_fin) begin
               if ((op_q == OP_STATUS) || (idx == len_q - LEN_W'(1)))
                  st <= ST_DONE;
               else
                  idx <= idx + LEN_W'(1);
            end
            ST_WDATA: if (cyc_fin) begin
               if (idx == len_q - LEN_W'(1)) st <= ST_CONF;
               else                          idx <= idx + LEN_W'(1);
            end
            ST_CONF:  if (cyc_fin) st <= ST_SETTLE;
            ST_STCMD: if (cyc_fin) st <= ST_STRD;
            ST_STRD:  if (cyc_fin) begin
               fail <= cap_byte[0];
               st   <= ST_DONE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st)
         ST_CMD:   bus_byte = first_code(op_q);
         ST_ADDR: begin
            if (op_q == OP_RD_ID)      bus_byte = 8'h00;
            else if (op_q == OP_ERASE) bus_byte = (idx == '0) ? addr_q[15:8] : addr_q[23:16];
            else if (idx == '0)        bus_byte = addr_q[7:0];
            else if (idx == LEN_W'(1)) bus_byte = addr_q[15:8];
            else                       bus_byte = addr_q[23:16];
         end
         ST_WDATA: bus_byte = wr_data;
         ST_CONF:  bus_byte = (op_q == OP_PROGRAM) ? CODE_PCONF : CODE_ECONF;
         ST_STCMD: bus_byte = CODE_STATUS;
         default:  bus_byte = 8'h00;
      endcase
   end

   assign bus_state = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_RDATA) ||
                      (st == ST_WDATA) || (st == ST_CONF) || (st == ST_STCMD) ||
                      (st == ST_STRD);
   assign cyc_start = bus_state && !cyc_active;
   assign cyc_rd    = (st == ST_RDATA) || (st == ST_STRD);
   assign cle       = (st == ST_CMD) || (st == ST_CONF) || (st == ST_STCMD);
   assign ale       = (st == ST_ADDR);
   assign oe        = cle || ale || (st == ST_WDATA);
   assign wr_take   = (st == ST_WDATA) && cyc_fin;
   assign busy      = (st != ST_IDLE);
   assign done      = (st == ST_DONE);
   assign guard_off = busy && ((op_q == OP_PROGRAM) || (op_q == OP_ERASE));

endmodule

// File: rtl/nand_seq.sv
`timescale 1ns/1ps
module nand_seq
   import nand_seq_pkg::*;
#(
   parameter int LEN_W     = 10,
   parameter int STROBE_LO = 2,
   parameter int STROBE_HI = 2,
   parameter int WB_CYC    = 4,
   parameter bit EXT_MODE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [7:0]        wr_data,
   output logic              wr_take,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              nand_ce_n,
   output logic              nand_cle,
   output logic              nand_ale,
   output logic              nand_we_n,
   output logic              nand_re_n,
   output logic              nand_wp_n,
   output logic [7:0]        nand_io_out,
   output logic              nand_io_oe,
   input  logic [7:0]        nand_io_in,
   input  logic              nand_rb
);
   generate
      if (STROBE_LO < 1 || STROBE_HI < 1) begin : g_bad_strobe
         $error("nand_seq: strobe phases need at least one clock");
      end
      if (WB_CYC < 1) begin : g_bad_wb
         $error("nand_seq: WB_CYC must be at least 1");
      end
      if (LEN_W < 2) begin : g_bad_len
         $error("nand_seq: LEN_W must be at least 2");
      end
   endgenerate

   logic       cyc_start, cyc_rd, cyc_active, cyc_fin;
   logic [7:0] cap_byte;
   logic       guard_off;

   nand_seq_strobe #(
      .STROBE_LO (STROBE_LO),
      .STROBE_HI (STROBE_HI)
   ) u_strobe (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (cyc_start),
      .is_read  (cyc_rd),
      .io_in    (nand_io_in),
      .active   (cyc_active),
      .fin      (cyc_fin),
      .we_n     (nand_we_n),
      .re_n     (nand_re_n),
      .cap_byte (cap_byte)
   );

   nand_seq_ctrl #(
      .LEN_W    (LEN_W),
      .WB_CYC   (WB_CYC),
      .EXT_MODE (EXT_MODE)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_op     (req_op),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .wr_data    (wr_data),
      .nand_rb    (nand_rb),
      .cyc_active (cyc_active),
      .cyc_fin    (cyc_fin),
      .cap_byte   (cap_byte),
      .cyc_start  (cyc_start),
      .cyc_rd     (cyc_rd),
      .bus_byte   (nand_io_out),
      .cle        (nand_cle),
      .ale        (nand_ale),
      .oe         (nand_io_oe),
      .wr_take    (wr_take),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .busy       (busy),
      .done       (done),
      .fail       (fail),
      .guard_off  (guard_off)
   );

   assign nand_ce_n = !busy;
   assign nand_wp_n = guard_off;

endmodule

// File: rtl/nand_seq_chk.sv
`timescale 1ns/1ps
module nand_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic busy,
   input logic done,
   input logic nand_ce_n,
   input logic nand_cle,
   input logic nand_ale,
   input logic nand_we_n,
   input logic nand_re_n,
   input logic nand_wp_n,
   input logic nand_io_oe
);
   // R2
   cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nand_cle && nand_ale));
   // R11
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));
   // R11
   read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !nand_io_oe);
   // R4
   ale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_ale && !nand_we_n) |=> nand_ale);
   // R10
   done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R10
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));
   // R12
   ce_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> nand_ce_n);
   // R12
   wp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !nand_wp_n);
endmodule

bind nand_seq nand_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .busy       (busy),
   .done       (done),
   .nand_ce_n  (nand_ce_n),
   .nand_cle   (nand_cle),
   .nand_ale   (nand_ale),
   .nand_we_n  (nand_we_n),
   .nand_re_n  (nand_re_n),
   .nand_wp_n  (nand_wp_n),
   .nand_io_oe (nand_io_oe)
);

// File: tb/nand_seq_test.sv
`timescale 1ns/1ps
module nand_seq_test;
   localparam int LEN_W = 10;
   localparam int SLO   = 2;
   localparam int BUSY_T = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [2:0] req_op = '0;
   logic [23:0] req_addr = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic [7:0] wr_data = '0;
   logic wr_take, rd_valid, busy, done, fail;
   logic [7:0] rd_data, nand_io_out;
   logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_io_oe;
   logic [7:0] nand_io_in = '0;
   logic nand_rb;

   always #4 clk = ~clk;

   nand_seq #(.LEN_W(LEN_W), .STROBE_LO(SLO), .STROBE_HI(2), .WB_CYC(4), .EXT_MODE(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_len(req_len), .wr_data(wr_data), .wr_take(wr_take),
      .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done), .fail(fail),
      .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_wp_n(nand_wp_n),
      .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in),
      .nand_rb(nand_rb));

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   // device model state
   logic [9:0] log_q[$];
   logic [7:0] rd_q[$];
   logic [7:0] wr_q[$];
   logic [7:0] last_cmd = 8'hFF;
   logic [7:0] status_val = 8'hC0;
   int busy_left = 0;
   bit hold_busy = 0;
   int rd_k = 0;
   int ale_rises = 0;
   int done_cnt = 0;
   int viol_cmd = 0, viol_re = 0, strobe_err = 0;
   int we_low = 0, re_low = 0;
   logic pwe = 1, pre = 1, pale = 0;

   // reference state for per-clock comparison
   bit exp_busy = 0;
   logic [2:0] exp_op = '0;
   logic p_req = 0, p_done = 0, p_rst = 0;
   logic [2:0] p_op = '0;

   assign nand_rb = !(busy_left > 0 || hold_busy);

   function automatic logic [7:0] page_byte(int k);
      return 8'(k * 7 + 8'h31);
   endfunction
   function automatic logic [7:0] id_byte(int k);
      return (k == 0) ? 8'hEC : 8'(8'h70 + k);
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         // write strobe rising: capture bus cycle
         if (nand_we_n && !pwe) begin
            logic [1:0] ty;
            ty = {nand_ale, nand_cle};
            log_q.push_back({ty, nand_io_out});
            if (we_low != SLO) strobe_err++;
            if (nand_cle) begin
               if (!nand_rb && nand_io_out != 8'h70 && nand_io_out != 8'hFF && nand_io_out != 8'hB0)
                  viol_cmd++;
               last_cmd = nand_io_out;
               rd_k = 0;
               if (nand_io_out == 8'h10 || nand_io_out == 8'hD0 || nand_io_out == 8'hFF || nand_io_out == 8'hB0)
                  busy_left = BUSY_T;
            end
         end
         if (!nand_re_n && pre) begin
            if (!nand_rb && last_cmd != 8'h70) viol_re++;
            if (last_cmd == 8'h70)      nand_io_in = status_val;
            else if (last_cmd == 8'h90) nand_io_in = id_byte(rd_k);
            else                        nand_io_in = page_byte(rd_k);
            rd_k++;
         end
         if (nand_re_n && !pre && re_low != SLO) strobe_err++;
         if (nand_ale && !pale) ale_rises++;
         if (!nand_ale && pale && (last_cmd == 8'h00 || last_cmd == 8'h50)) busy_left = BUSY_T;
         we_low = nand_we_n ? 0 : we_low + 1;
         re_low = nand_re_n ? 0 : re_low + 1;
         if (busy_left > 0) busy_left--;
         if (rd_valid) rd_q.push_back(rd_data);
         if (done) done_cnt++;
         if (wr_take) begin
            void'(wr_q.pop_front());
            wr_data = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
         end
         // per-clock reference comparison
         if (p_rst) begin
            if (exp_busy) exp_busy = !p_done;
            else if (p_req) begin exp_busy = 1; exp_op = p_op; end
            chk(busy == exp_busy, "R10 busy", busy, exp_busy);
            chk(nand_ce_n == !exp_busy, "R12 ce_n", nand_ce_n, !exp_busy);
            chk(nand_wp_n == (exp_busy && (exp_op == 3'd4 || exp_op == 3'd5)), "R12 wp_n",
                nand_wp_n, exp_busy && (exp_op == 3'd4 || exp_op == 3'd5));
         end
      end
      pwe = nand_we_n; pre = nand_re_n; pale = nand_ale;
      p_req = req_valid; p_op = req_op; p_done = done; p_rst = rst_n;
   end

   task automatic start_req(input logic [2:0] op, input logic [23:0] a, input int len);
      @(negedge clk);
      log_q.delete(); rd_q.delete();
      ale_rises = 0; done_cnt = 0;
      req_op = op; req_addr = a; req_len = LEN_W'(len); req_valid = 1;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wait_done(input string req);
      int n;
      n = 0;
      while (!done && n < 5000) begin @(negedge clk); n++; end
      chk(n < 5000, req, n, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic check_log(input string req, input logic [9:0] exp[$]);
      bit ok;
      ok = (exp.size() == log_q.size());
      for (int i = 0; ok && i < exp.size(); i++) if (exp[i] != log_q[i]) ok = 0;
      chk(ok, req, (log_q.size() > 0) ? int'(log_q[log_q.size()-1]) : -1,
          (exp.size() > 0) ? int'(exp[exp.size()-1]) : -1);
   endtask

   // entry helpers: {ale,cle,byte}
   function automatic logic [9:0] C(logic [7:0] b); return {2'b01, b}; endfunction
   function automatic logic [9:0] A(logic [7:0] b); return {2'b10, b}; endfunction
   function automatic logic [9:0] D(logic [7:0] b); return {2'b00, b}; endfunction

   initial begin
      logic [9:0] e[$];
      bit ok;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!busy && !done && !wr_take && !rd_valid && !nand_cle && !nand_ale && !nand_io_oe &&
          !nand_wp_n && nand_ce_n && nand_we_n && nand_re_n, "R1 reset outputs", busy, 0);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // R9 R3 R2 page read
      start_req(3'd0, 24'h345612, 5);
      wait_done("R9 page read completes");
      e = '{C(8'h00), A(8'h12), A(8'h56), A(8'h34)};
      check_log("R3 page read cycles", e);
      chk(ale_rises == 1, "R4 ale single run", ale_rises, 1);
      ok = (rd_q.size() == 5);
      for (int i = 0; ok && i < 5; i++) if (rd_q[i] != page_byte(i)) ok = 0;
      chk(ok, "R9 page data order", rd_q.size(), 5);

      // R2 spare read
      start_req(3'd1, 24'h000007, 3);
      wait_done("R2 spare read completes");
      e = '{C(8'h50), A(8'h07), A(8'h00), A(8'h00)};
      check_log("R2 spare read cycles", e);
      chk(rd_q.size() == 3 && rd_q[2] == page_byte(2), "R9 spare data", rd_q.size(), 3);

      // R3 ID read
      start_req(3'd2, 24'hABCDEF, 2);
      wait_done("R3 id read completes");
      e = '{C(8'h90), A(8'h00)};
      check_log("R3 id read cycles", e);
      chk(rd_q.size() == 2 && rd_q[0] == 8'hEC && rd_q[1] == 8'h71, "R9 id bytes",
          (rd_q.size() > 0) ? int'(rd_q[0]) : -1, 8'hEC);

      // R8 status while device busy
      hold_busy = 1;
      status_val = 8'hE0;
      start_req(3'd3, 24'h0, 1);
      wait_done("R8 status during busy");
      e = '{C(8'h70)};
      check_log("R8 status cycles", e);
      chk(rd_q.size() == 1 && rd_q[0] == 8'hE0, "R9 status byte returned",
          (rd_q.size() > 0) ? int'(rd_q[0]) : -1, 8'hE0);

      // R8 gating of a non-exempt op
      start_req(3'd2, 24'h0, 1);
      repeat (40) @(negedge clk);
      chk(log_q.size() == 0, "R8 no command while busy", log_q.size(), 0);
      chk(busy == 1, "R8 request held pending", busy, 1);
      hold_busy = 0;
      wait_done("R8 gated op completes");
      e = '{C(8'h90), A(8'h00)};
      check_log("R8 gated op cycles", e);

      // R5 R7 program pass
      status_val = 8'hC0;
      wr_q = '{8'h11, 8'h22, 8'h33, 8'h44};
      wr_data = wr_q[0];
      start_req(3'd4, 24'h0A0B0C, 4);
      wait_done("R5 program completes");
      e = '{C(8'h80), A(8'h0C), A(8'h0B), A(8'h0A), D(8'h11), D(8'h22), D(8'h33), D(8'h44),
            C(8'h10), C(8'h70)};
      check_log("R5 program cycles", e);
      chk(wr_q.size() == 0, "R5 all bytes taken", wr_q.size(), 0);
      chk(fail == 0, "R7 program pass", fail, 0);

      // R6 R7 erase fail
      status_val = 8'hC1;
      start_req(3'd5, 24'h776600, 1);
      wait_done("R6 erase completes");
      e = '{C(8'h60), A(8'h66), A(8'h77), C(8'hD0), C(8'h70)};
      check_log("R6 erase cycles", e);
      chk(fail == 1, "R7 erase fail bit", fail, 1);

      // R8 reset issued while busy, then waits
      hold_busy = 1;
      start_req(3'd6, 24'h0, 1);
      repeat (30) @(negedge clk);
      e = '{C(8'hFF)};
      check_log("R8 reset issued during busy", e);
      chk(busy == 1, "R8 reset waits for ready", busy, 1);
      hold_busy = 0;
      wait_done("R8 reset completes");

      // R13 suspend
      hold_busy = 1;
      start_req(3'd7, 24'h0, 1);
      repeat (20) @(negedge clk);
      e = '{C(8'hB0)};
      check_log("R13 suspend issued", e);
      hold_busy = 0;
      wait_done("R13 suspend completes");

      // R10 request during busy is ignored
      start_req(3'd0, 24'h000102, 2);
      @(negedge clk);
      req_op = 3'd5; req_addr = 24'hFFFF00; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      wait_done("R10 first op completes");
      repeat (40) @(negedge clk);
      e = '{C(8'h00), A(8'h02), A(8'h01), A(8'h00)};
      check_log("R10 extra request ignored", e);
      chk(done_cnt == 1, "R10 single done", done_cnt, 1);
      chk(busy == 0, "R10 idle after", busy, 0);

      chk(viol_cmd == 0, "R8 no gated command while busy", viol_cmd, 0);
      chk(viol_re == 0, "R9 no array read while busy", viol_re, 0);
      chk(strobe_err == 0, "R11 strobe width", strobe_err, 0);

      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #1200000;
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule